// File: doc/BRIEF.md
# Write-Guarded Watchdog Timer

This block is a watchdog built around a 24-bit down-counter. The counter reloads from a 24-bit value held in three byte-wide reload registers. Software reaches those registers through a small byte-wide register bus. Because a stray store must not be able to stretch or shorten the timeout, the reload registers are guarded. Two key bytes must first be stored to the control/status address. After that, the three reload bytes must be stored most significant first. Any store that breaks this order locks the registers again.

The control/status address is read-only. It reports why the chip last came out of reset: power-on, external pin, watchdog expiry, or recovery from stop mode. It also shows the current stop-mode level. The four cause bits are sticky, and reading the register clears them. The counter runs while the enable input is high. It restarts from the reload value when it is first enabled and on each refresh pulse. When it runs down to zero, it emits a one-cycle timeout pulse and starts over.

Top module: `wdog_guard`

## Requirements
- R1: After reset, the status byte reads 0x00 while all cause inputs and stop_mode are low, timeout is low, and the reload registers read back the parameter RELOAD_RST (default 0x000FFF).
- R2: Two stores to address 0xFF0 open the reload window: 0xAA first, then 0x55. In that window, the reload bytes are stored at 0xFF1 (bits 23..16), 0xFF2 (bits 15..8) and 0xFF3 (bits 7..0), and each byte takes effect as it is stored.
- R3: The reload bytes are accepted only in the order 0xFF1, 0xFF2, 0xFF3. A store to a reload address out of turn is discarded and closes the window. After the 0xFF3 store, the window is closed.
- R4: Any bus store that is not the next expected step returns the guard to locked. The one exception is a store of 0xAA to 0xFF0, which always counts as a fresh first key. Stores to 0xFF1..0xFF3 while locked leave the reload registers unchanged.
- R5: Stores to 0xFF0, including both key bytes, never change the status byte.
- R6: The status byte at 0xFF0 has this layout: bit 7 power-on cause, bit 6 stop-recovery cause, bit 5 watchdog-expiry cause, bit 4 external cause, bits 3..1 always 0, and bit 0 the live stop_mode level.
- R7: A read of 0xFF0 returns the bits held before the read and then clears bits 7..4. If a cause is asserted in the same cycle as the read, that cause bit stays set. Bit 0 is not cleared by the read.
- R8: Each of cause_por, cause_ext and cause_stop_rec sets its status bit, and the bit stays set until a read of 0xFF0.
- R9: The counter loads the reload value on the first enabled cycle after enable rises, and on every cycle with refresh high while enabled.
- R10: While enabled, the counter steps down by one each clock. The cycle after it holds zero, timeout goes high for one cycle, status bit 5 sets, and the counter reloads. The first pulse therefore comes R+2 clocks after the loading edge's predecessor, and later pulses come every R+1 clocks.
- R11: While enable is low, timeout stays low and refresh is ignored.
- R12: Reads of 0xFF1..0xFF3 return the stored reload bytes whether the guard is locked or open. Reads of any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 8 | Store data |
| bus_we | input | 1 | Store strobe, one store per cycle |
| bus_re | input | 1 | Read strobe; reading 0xFF0 clears the cause bits |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| wd_enable | input | 1 | Counter runs while high |
| refresh | input | 1 | Restart the count from the reload value |
| cause_por | input | 1 | Power-on reset cause |
| cause_ext | input | 1 | External reset cause |
| cause_stop_rec | input | 1 | Stop-mode recovery cause |
| stop_mode | input | 1 | Live stop-mode level, shown in status bit 0 |
| timeout | output | 1 | One-cycle expiry pulse |

## Verification
Read data is combinational, so the bench samples bus_rdata one time step after it drives the address at a falling edge, before the clear takes effect at the next rising edge. Effects of bus stores and cause pulses are registered: they become visible in the read after the edge that captured them. The timeout pulse is a register behind the zero compare. With enable raised at a falling edge and the bench counting falling edges after the load, the pulse is sampled on count R+2 and then every R+1 counts. A refresh shifts the next pulse to R+2 counts after the refresh edge. The bench predicts each of these counts from the programmed reload value and compares them with what it observes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {LK_IDLE, LK_KEY1, LK_OPEN} lock_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  // sticky cause vector order (status bits 7..4): por, stop-recovery, expiry, external
  localparam int CS_POR = 3;
  localparam int CS_REC = 2;
  localparam int CS_TMO = 1;
  localparam int CS_EXT = 0;

  // set beats clear when both land in one cycle
  function automatic logic [3:0] sticky_next(logic [3:0] cur, logic [3:0] set, logic clr);
    return (clr ? 4'h0 : cur) | set;
  endfunction

  function automatic logic [7:0] status_pack(logic [3:0] sticky, logic stop_lvl);
    return {sticky, 3'b000, stop_lvl};
  endfunction
endpackage

// File: rtl/wdog_lock.sv
module wdog_lock import wdog_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int NBYTES = 3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hFF0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [NBYTES-1:0] byte_wr,
  output logic              window_open
);
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBYTES - 1);

  lock_e            st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             hit_ctrl, fresh_key;
  logic [ADDR_W-1:0] want_addr;

  assign hit_ctrl  = we && (addr == CTRL_ADDR);
  assign fresh_key = hit_ctrl && (wdata == KEY_FIRST);
  assign want_addr = CTRL_ADDR + ADDR_W'(idx_q) + ADDR_W'(1);

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    byte_wr = '0;
    if (we) begin
      st_d  = fresh_key ? LK_KEY1 : LK_IDLE;
      idx_d = '0;
      case (st_q)
        LK_KEY1: if (hit_ctrl && wdata == KEY_SECOND) st_d = LK_OPEN;
        LK_OPEN: if (addr == want_addr) begin
          byte_wr[idx_q] = 1'b1;
          if (idx_q != IDX_LAST) begin
            st_d  = LK_OPEN;
            idx_d = idx_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LK_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign window_open = (st_q == LK_OPEN);
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 24
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             refresh,
  input  logic [CNT_W-1:0] reload,
  output logic             load_evt,
  output logic             tmo_event,
  output logic [CNT_W-1:0] cnt_q,
  output logic             timeout
);
  logic en_q;

  assign load_evt  = enable && (!en_q || refresh);
  assign tmo_event = enable && !load_evt && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      cnt_q   <= '0;
      timeout <= 1'b0;
    end else begin
      en_q    <= enable;
      timeout <= tmo_event;
      if (load_evt || tmo_event) cnt_q <= reload;
      else if (enable)           cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_status.sv
module wdog_status import wdog_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] set_vec,
  input  logic       clr,
  input  logic       stop_lvl,
  output logic [3:0] sticky_q,
  output logic [7:0] stat_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= 4'h0;
    else        sticky_q <= sticky_next(sticky_q, set_vec, clr);
  end

  assign stat_byte = status_pack(sticky_q, stop_lvl);
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard import wdog_pkg::*; #(
  parameter int CNT_W = 24,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hFF0,
  parameter logic [CNT_W-1:0] RELOAD_RST = 'h000FFF
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  input  logic              wd_enable,
  input  logic              refresh,
  input  logic              cause_por,
  input  logic              cause_ext,
  input  logic              cause_stop_rec,
  input  logic              stop_mode,
  output logic              timeout
);
  localparam int NBYTES = CNT_W / 8;

  logic [NBYTES-1:0] byte_wr;
  logic              window_open;
  logic [CNT_W-1:0]  rel_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              load_evt, tmo_event;
  logic [3:0]        set_vec, stat_sticky;
  logic              stat_clr;
  logic [7:0]        stat_byte;

  wdog_lock #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .CTRL_ADDR(CTRL_ADDR)) u_lock (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .byte_wr(byte_wr), .window_open(window_open)
  );

  // byte 0 is the most significant
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= RELOAD_RST;
    else
      for (int i = 0; i < NBYTES; i++)
        if (byte_wr[i]) rel_q[CNT_W-1-8*i -: 8] <= bus_wdata;
  end

  wdog_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(wd_enable), .refresh(refresh), .reload(rel_q),
    .load_evt(load_evt), .tmo_event(tmo_event), .cnt_q(cnt_q), .timeout(timeout)
  );

  always_comb begin
    set_vec         = 4'h0;
    set_vec[CS_POR] = cause_por;
    set_vec[CS_REC] = cause_stop_rec;
    set_vec[CS_TMO] = tmo_event;
    set_vec[CS_EXT] = cause_ext;
  end

  assign stat_clr = bus_re && (bus_addr == CTRL_ADDR);

  wdog_status u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr(stat_clr), .stop_lvl(stop_mode),
    .sticky_q(stat_sticky), .stat_byte(stat_byte)
  );

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == CTRL_ADDR) bus_rdata = stat_byte;
    for (int i = 0; i < NBYTES; i++)
      if (bus_addr == CTRL_ADDR + ADDR_W'(i + 1)) bus_rdata = rel_q[CNT_W-1-8*i -: 8];
  end
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk import wdog_pkg::*; #(
  parameter int CNT_W = 24
)(
  input logic             clk,
  input logic             rst_n,
  input logic             wd_enable,
  input logic             refresh,
  input logic             timeout,
  input logic             load_evt,
  input logic             window_open,
  input logic [CNT_W-1:0] rel_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [3:0]       stat_sticky,
  input logic [3:0]       set_vec,
  input logic             stat_clr,
  input logic             cause_ext
);
  // R10: a pulse followed by a nonzero reload lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timeout && cnt_q != '0 |=> !timeout);

  // R10: expiry cause is recorded by the time the pulse shows
  a_r10_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> stat_sticky[CS_TMO]);

  // R10: one step down per enabled clock
  a_r10_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    wd_enable && !load_evt && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);

  // R4: reload bytes frozen outside the open window
  a_r4_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !window_open |=> $stable(rel_q));

  // R9: refresh while enabled restarts the count
  a_r9_refresh_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wd_enable && refresh |=> cnt_q == $past(rel_q));

  // R11: no pulse and frozen count while disabled
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_enable |=> !timeout && $stable(cnt_q));

  // R7: set wins against a same-cycle read
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cause_ext |=> stat_sticky[CS_EXT]);

  // R7: read with nothing arriving empties the cause bits
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr && set_vec == 4'h0 |=> stat_sticky == 4'h0);
endmodule

bind wdog_guard wdog_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wd_enable(wd_enable), .refresh(refresh), .timeout(timeout),
  .load_evt(load_evt), .window_open(window_open), .rel_q(rel_q), .cnt_q(cnt_q),
  .stat_sticky(stat_sticky), .set_vec(set_vec), .stat_clr(stat_clr), .cause_ext(cause_ext)
);

// File: tb/wdog_guard_test.sv
`timescale 1ns/1ps
module wdog_guard_test;
  localparam logic [11:0] A_ST = 12'hFF0;
  localparam int RV = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic bus_we = 0, bus_re = 0, wd_enable = 0, refresh = 0;
  logic cause_por = 0, cause_ext = 0, cause_stop_rec = 0, stop_mode = 0;
  logic timeout;

  int n_cmp = 0, n_bad = 0;
  int mstate = 0;
  logic [7:0] m_rel [3];

  always #4 clk = ~clk;

  wdog_guard uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rdata(bus_rdata), .wd_enable(wd_enable), .refresh(refresh),
    .cause_por(cause_por), .cause_ext(cause_ext), .cause_stop_rec(cause_stop_rec),
    .stop_mode(stop_mode), .timeout(timeout)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model of the guard: 0 locked, 1 first key seen, 2..4 waiting for byte 0..2
  function automatic void model_wr(input logic [11:0] a, input logic [7:0] d);
    if (mstate == 1 && a == A_ST && d == 8'h55) mstate = 2;
    else if (mstate >= 2 && a == A_ST + 12'(mstate - 1)) begin
      m_rel[mstate-2] = d;
      mstate = (mstate == 4) ? 0 : mstate + 1;
    end else mstate = (a == A_ST && d == 8'hAA) ? 1 : 0;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1 bus_we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_re = 1'b0;
  endtask

  task automatic chk_reload(input string req);
    logic [7:0] d;
    for (int i = 0; i < 3; i++) begin
      rd(A_ST + 12'(i + 1), d);
      chk(req, d, m_rel[i]);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] d;
    int seen [2];
    int nseen, j;
    m_rel[0] = 8'h00; m_rel[1] = 8'h0F; m_rel[2] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 timeout", timeout, 0);
    rd(A_ST, d); chk("R1 status", d, 8'h00);
    chk_reload("R1 reload");

    // R12 unmapped address
    rd(12'hFF4, d); chk("R12 unmapped", d, 8'h00);

    // R2 full unlock and write
    wr(A_ST, 8'hAA); wr(A_ST, 8'h55);
    wr(12'hFF1, 8'h12); wr(12'hFF2, 8'h34); wr(12'hFF3, 8'h56);
    chk("R2 model", mstate, 0);
    chk_reload("R2 reload");
    // R2 byte takes effect alone, then window broken
    wr(A_ST, 8'hAA); wr(A_ST, 8'h55); wr(12'hFF1, 8'h9A);
    wr(A_ST, 8'h00); wr(12'hFF2, 8'hEE);
    rd(12'hFF1, d); chk("R2 upper alone", d, 8'h9A);
    rd(12'hFF2, d); chk("R4 abort keeps high", d, 8'h34);

    // R3 out of order
    wr(A_ST, 8'hAA); wr(A_ST, 8'h55); wr(12'hFF2, 8'h77); wr(12'hFF1, 8'h66);
    rd(12'hFF2, d); chk("R3 out of order", d, 8'h34);
    rd(12'hFF1, d); chk("R3 relocked", d, 8'h9A);

    // R4 interrupted keys, and restart by a repeated first key
    wr(A_ST, 8'hAA); wr(12'hFF4, 8'h00); wr(A_ST, 8'h55); wr(12'hFF1, 8'h01);
    rd(12'hFF1, d); chk("R4 interrupted", d, 8'h9A);
    wr(A_ST, 8'hAA); wr(A_ST, 8'hAA); wr(A_ST, 8'h55); wr(12'hFF1, 8'h02);
    rd(12'hFF1, d); chk("R4 restart key", d, 8'h02);

    // R8/R6 cause bits
    @(negedge clk) cause_por = 1; @(negedge clk) cause_por = 0;
    rd(A_ST, d); chk("R8 por bit7", d, 8'h80);
    rd(A_ST, d); chk("R7 cleared", d, 8'h00);
    @(negedge clk) cause_stop_rec = 1; @(negedge clk) cause_stop_rec = 0;
    rd(A_ST, d); chk("R6 stop-recovery bit6", d, 8'h40);
    stop_mode = 1;
    rd(A_ST, d); chk("R6 stop level bit0", d, 8'h01);
    rd(A_ST, d); chk("R7 bit0 not cleared", d, 8'h01);
    stop_mode = 0;

    // R7 set wins over clear
    @(negedge clk) cause_ext = 1;
    rd(A_ST, d); chk("R8 ext bit4", d, 8'h10);
    cause_ext = 0;
    rd(A_ST, d); chk("R7 set wins", d, 8'h10);
    rd(A_ST, d); chk("R7 clear after", d, 8'h00);

    // random guarded sequences; R5 status must survive them
    @(negedge clk) cause_ext = 1; @(negedge clk) cause_ext = 0;
    void'($urandom(32'd8675309));
    for (int it = 0; it < 120; it++) begin
      logic [11:0] sa [5];
      logic [7:0]  sd [5];
      sa[0] = A_ST; sd[0] = 8'hAA; sa[1] = A_ST; sd[1] = 8'h55;
      for (int k = 2; k < 5; k++) begin sa[k] = A_ST + 12'(k - 1); sd[k] = 8'($urandom); end
      for (int k = 0; k < 5; k++) begin
        if ($urandom_range(0, 9) < 2) begin
          sa[k] = A_ST + 12'($urandom_range(0, 4));
          sd[k] = ($urandom_range(0, 1) == 1) ? 8'hAA : 8'($urandom);
        end
        wr(sa[k], sd[k]);
      end
      if (it % 8 == 0) chk_reload("R3 random order");
    end
    chk_reload("R4 random final");
    rd(A_ST, d); chk("R5 status after key stores", d, 8'h10);

    // program reload = RV
    wr(A_ST, 8'hAA); wr(A_ST, 8'h55);
    wr(12'hFF1, 8'h00); wr(12'hFF2, 8'h00); wr(12'hFF3, 8'(RV));

    // R9/R10 period from first enable
    nseen = 0;
    @(negedge clk) wd_enable = 1;
    for (int k = 1; k <= 60; k++) begin
      @(posedge clk); @(negedge clk);
      if (timeout) begin
        if (nseen < 2) seen[nseen] = k;
        nseen++;
      end
    end
    chk("R10 pulse count", nseen, 2);
    chk("R9 first pulse", seen[0], RV + 2);
    chk("R10 period", seen[1], 2 * RV + 3);

    // R9 refresh restarts count
    wd_enable = 0; @(negedge clk) wd_enable = 1;
    repeat (10) @(negedge clk);
    refresh = 1; @(posedge clk); @(negedge clk) refresh = 0;
    j = 1;
    while (!timeout && j < 60) begin @(posedge clk); @(negedge clk); j++; end
    chk("R9 refresh delay", j, RV + 2);

    // R11 disabled: no pulses, refresh ignored
    wd_enable = 0; nseen = 0;
    for (int k = 0; k < 60; k++) begin
      refresh = (k % 7 == 0);
      @(posedge clk); @(negedge clk);
      if (timeout) nseen++;
    end
    refresh = 0;
    chk("R11 no pulse", nseen, 0);
    rd(A_ST, d); chk("R10 expiry bit5", d, 8'h20);
    rd(A_ST, d); chk("R7 bit5 cleared", d, 8'h00);

    summary();
  end
endmodule